// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable, parameterised model of a synchronous static memory with a 32-bit word made of four byte lanes. Every control and data input is sampled on the rising clock edge. A read returns through a registered output pipeline. The data port is split into an input bus, an output bus and an output-valid qualifier, so the chip top level can build the tri-state pad.

An access begins on an edge where the active-low address strobe is low. On that edge the address and chip enable are loaded. A selected access is a read or a write, depending on the global write gate and the byte enables. On edges where the strobe is high, the held address is used again without change. These edges act as read or write wait cycles of the current access, and chip enable has no effect on them. The output enable is active low and asynchronous, and it only gates the output qualifier. After a read is strobed, its word appears on the output after the next two rising edges. Reads issued on consecutive edges return one word per cycle.

Top module: `burst_sram`

## Requirements
- R1: A selected write with `gweN` low and all of `beN` low stores the whole `din` word at the held address, and a later read of that address returns it.
- R2: `beN[n]` low writes only bits [8n+7:8n] (lane 0 is bits 7:0, lane 3 is bits 31:24). Lanes whose enable is high keep their stored bits.
- R3: When `gweN` is high the cycle is a read whatever `beN` is, and memory is not changed. When `gweN` is low but every `beN` bit is high, the cycle is also a read.
- R4: `addr` and `ceN` are loaded only on edges where `adsN` is low. On edges where `adsN` is high, the access reads or writes the held address, does not advance it, and ignores `ceN` and `addr`.
- R5: An edge with `adsN` low and `ceN` high deselects the block. Later edges with `adsN` high then do nothing, and writes are dropped. From the third edge after the deselect, `doutEn` stays low until a strobe selects the block again.
- R6: A read accepted on edge k drives `doutEn` high with the read word on `dout` after edge k+2, and this holds until edge k+3. Reads on consecutive edges give one word per cycle.
- R7: A write accepted on edge k leaves `doutEn` low after edge k+2.
- R8: While `oeN` is high, `doutEn` is low at once, even while a read word is in the output stage.
- R9: `doutEn` is low during reset and after reset until the first selected read reaches the output.
- R10: A write strobed on the edge right after a read is accepted. A read just before a write to the same address returns the old word, and a read just after it returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address, loaded on strobe edges |
| ceN | input | 1 | Active-low chip enable, loaded on strobe edges |
| adsN | input | 1 | Active-low address strobe |
| gweN | input | 1 | Active-low global write gate |
| beN | input | 4 | Active-low byte-lane write enables |
| oeN | input | 1 | Active-low asynchronous output enable |
| din | input | 32 | Write data |
| dout | output | 32 | Read data from the output stage |
| doutEn | output | 1 | High when the top level should drive `dout` onto the pad |

## Verification
Assertions check four things on every cycle. A read, wherever it sits in the traffic, must raise the output qualifier three edges later unless output enable is high. Writes and deselects must leave the qualifier low at that point. Output enable high forces the qualifier low, and the held address stays stable across non-strobe edges. Only the bench scenarios can show that the data itself is right: byte-lane merging, wait cycles that reuse the held address, writes dropped while deselected, and the old-or-new word order around a read followed by a write. For each of these, every output word is compared against a reference memory.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  parameter int unsigned BS_LANES  = 4;
  parameter int unsigned BS_LANE_W = 8;
  localparam int unsigned BS_WORD_W = BS_LANES * BS_LANE_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                memWr;    // commit a write this edge
    logic [BS_LANES-1:0] laneWr;   // lanes to write
    logic                rdLaunch; // read the array into stage 1
    logic                outLoad;  // move stage 1 into the output stage
  } bsram_strb_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ceN,
  input  logic                adsN,
  input  logic                gweN,
  input  logic [BS_LANES-1:0] beN,
  output logic [ADDR_W-1:0]   addrQ,
  output bsram_strb_t         strb,
  output logic                outValid
);
  localparam logic [BS_LANES-1:0] NoLanes = '1;

  logic                selQ;
  logic                accQ;
  logic                wrQ;
  logic [BS_LANES-1:0] laneQ;
  logic                rdV1;

  logic effSel;
  logic isWrite;

  always_comb begin
    effSel  = adsN ? selQ : ~ceN;
    isWrite = ~gweN && (beN != NoLanes);
  end

  // input stage: capture request on every edge, address only on strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      addrQ <= '0;
      accQ  <= 1'b0;
      wrQ   <= 1'b0;
      laneQ <= '0;
    end else begin
      if (!adsN) begin
        selQ  <= ~ceN;
        addrQ <= addr;
      end
      accQ  <= effSel;
      wrQ   <= isWrite;
      laneQ <= isWrite ? ~beN : '0;
    end
  end

  // read valid pipeline
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdV1     <= 1'b0;
      outValid <= 1'b0;
    end else begin
      rdV1     <= accQ && !wrQ;
      outValid <= rdV1;
    end
  end

  always_comb begin
    strb.memWr    = accQ && wrQ;
    strb.laneWr   = laneQ;
    strb.rdLaunch = accQ && !wrQ;
    strb.outLoad  = rdV1;
  end
endmodule

// File: rtl/bsram_dpath.sv
module bsram_dpath
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 clk,
  input  logic [ADDR_W-1:0]    addrQ,
  input  bsram_strb_t          strb,
  input  logic [BS_WORD_W-1:0] din,
  output logic [BS_WORD_W-1:0] dout
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [BS_WORD_W-1:0] dinQ;
  logic [BS_WORD_W-1:0] stage1;

  always_ff @(posedge clk) begin
    dinQ <= din;
  end

  for (genvar g = 0; g < BS_LANES; g++) begin : gLane
    logic [BS_LANE_W-1:0] laneMem [Depth];

    always_ff @(posedge clk) begin
      if (strb.memWr && strb.laneWr[g]) begin
        laneMem[addrQ] <= dinQ[g*BS_LANE_W +: BS_LANE_W];
      end
      if (strb.rdLaunch) begin
        stage1[g*BS_LANE_W +: BS_LANE_W] <= laneMem[addrQ];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.outLoad) begin
      dout <= stage1;
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ceN,
  input  logic                 adsN,
  input  logic                 gweN,
  input  logic [BS_LANES-1:0]  beN,
  input  logic                 oeN,
  input  logic [BS_WORD_W-1:0] din,
  output logic [BS_WORD_W-1:0] dout,
  output logic                 doutEn
);
  bsram_strb_t       strb;
  logic [ADDR_W-1:0] addrQ;
  logic              outValid;

  bsram_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .adsN(adsN),
    .gweN(gweN), .beN(beN), .addrQ(addrQ), .strb(strb), .outValid(outValid)
  );

  bsram_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .addrQ(addrQ), .strb(strb), .din(din), .dout(dout)
  );

  // output enable gates the drive qualifier asynchronously
  assign doutEn = outValid && !oeN;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                ceN,
  input logic                adsN,
  input logic                gweN,
  input logic [BS_LANES-1:0] beN,
  input logic                oeN,
  input logic                doutEn,
  input logic [ADDR_W-1:0]   heldAddr
);
  logic selT;
  always_ff @(posedge clk) begin
    if (!rstN) selT <= 1'b0;
    else if (!adsN) selT <= ~ceN;
  end

  logic chkSel, chkWr, readReq, writeReq;
  always_comb begin
    chkSel   = adsN ? selT : ~ceN;
    chkWr    = !gweN && (beN != '1);
    readReq  = chkSel && !chkWr;
    writeReq = chkSel && chkWr;
  end

  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN) oeN |-> !doutEn); // R8
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN) (!adsN && ceN) |-> ##3 !doutEn); // R5
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN) readReq |-> ##3 (oeN || doutEn)); // R6
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN) writeReq |-> ##3 !doutEn); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !doutEn); // R9
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN) adsN |=> $stable(heldAddr)); // R4
endmodule

bind burst_sram bsram_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .adsN(adsN), .gweN(gweN), .beN(beN),
  .oeN(oeN), .doutEn(doutEn), .heldAddr(addrQ)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ceN = 1'b1, adsN = 1'b1, gweN = 1'b1, oeN = 1'b0;
  logic [3:0]    beN = 4'hF;
  logic [31:0]   din = '0;
  logic [31:0]   dout;
  logic          doutEn;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .adsN(adsN), .gweN(gweN),
    .beN(beN), .oeN(oeN), .din(din), .dout(dout), .doutEn(doutEn)
  );

  int nRun = 0, nFail = 0;
  bit done = 0;

  logic [31:0]   refMem [DEPTH];
  logic          refSel = 0;
  logic [AW-1:0] refAddr = '0;
  logic          h0V = 0, h1V = 0, h2V = 0;
  logic [31:0]   h0D = '0, h1D = '0, h2D = '0;

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mergeLanes(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int n = 0; n < 4; n++) if (!be[n]) r[n*8 +: 8] = nw[n*8 +: 8];
    return r;
  endfunction

  // reference model of one edge; returns a read result or nothing
  task automatic modelEdge(input logic a, input logic c, input logic g, input logic [3:0] b,
                           input logic [AW-1:0] ad, input logic [31:0] d,
                           output logic v, output logic [31:0] q);
    logic sel;
    sel = a ? refSel : !c;
    if (!a) begin refSel = !c; refAddr = ad; end
    v = 0; q = '0;
    if (sel) begin
      if (!g && b != 4'hF) refMem[refAddr] = mergeLanes(refMem[refAddr], d, b);
      else begin v = 1; q = refMem[refAddr]; end
    end
  endtask

  // called at a negedge: drive one edge, then check the output two edges back
  task automatic doCycle(input string tag, input logic a, input logic c, input logic g,
                         input logic [3:0] b, input logic [AW-1:0] ad, input logic [31:0] d,
                         input logic oe);
    logic v; logic [31:0] q; logic expEn;
    h2V = h1V; h2D = h1D; h1V = h0V; h1D = h0D;
    adsN = a; ceN = c; gweN = g; beN = b; addr = ad; din = d; oeN = oe;
    modelEdge(a, c, g, b, ad, d, v, q);
    h0V = v; h0D = q;
    @(posedge clk); @(negedge clk);
    expEn = h2V && !oeN;
    check(oeN ? "R8" : tag, doutEn === expEn, {31'd0, doutEn}, {31'd0, expEn});
    if (expEn) check(tag, dout === h2D, dout, h2D);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] ad, input logic [31:0] d, input logic [3:0] b);
    doCycle(tag, 0, 0, 0, b, ad, d, 0);
  endtask
  task automatic rd(input string tag, input logic [AW-1:0] ad);
    doCycle(tag, 0, 0, 1, 4'h0, ad, $urandom, 0);
  endtask
  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) doCycle(tag, 0, 1, 1, 4'hF, '0, '0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    // R9: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", doutEn === 1'b0, {31'd0, doutEn}, 32'd0);
    end
    rstN = 1;
    idle("R9", 4);
    // R1: fill and read back, back-to-back reads (R6)
    for (int i = 0; i < DEPTH; i++) wr("R1", i[AW-1:0], 32'h1000_0001 * (i + 1), 4'h0);
    for (int i = 0; i < DEPTH; i++) rd("R1", i[AW-1:0]);
    idle("R6", 3);
    rd("R6", 4'd9); idle("R6", 4);
    // R2: byte lanes
    wr("R2", 4'd5, 32'hAABB_CCDD, 4'b1101); rd("R2", 4'd5);
    wr("R2", 4'd5, 32'h1122_3344, 4'b0110); rd("R2", 4'd5);
    wr("R2", 4'd6, 32'h5566_7788, 4'b0111); rd("R2", 4'd6); idle("R2", 3);
    // R3: gate high means read
    doCycle("R3", 0, 0, 1, 4'h0, 4'd6, 32'hDEAD_BEEF, 0);
    doCycle("R3", 0, 0, 0, 4'hF, 4'd6, 32'hFEED_F00D, 0);
    rd("R3", 4'd6); idle("R3", 3);
    // R4: wait cycles reuse held address, ceN ignored
    rd("R4", 4'd7);
    for (int i = 0; i < 3; i++) doCycle("R4", 1, 1, 1, 4'h0, 4'd9, '0, 0);
    doCycle("R4", 1, 1, 0, 4'h0, 4'd9, 32'h0BAD_CAFE, 0);
    rd("R4", 4'd7); rd("R4", 4'd9); idle("R4", 3);
    // R5: deselect, writes dropped, output quiet
    rd("R5", 4'd3);
    doCycle("R5", 0, 1, 1, 4'hF, 4'd3, '0, 0);
    for (int i = 0; i < 4; i++) doCycle("R5", 1, 0, 0, 4'h0, 4'd3, 32'h7777_7777, 0);
    rd("R5", 4'd3); idle("R5", 3);
    // R7: writes do not drive
    for (int i = 0; i < 4; i++) wr("R7", i[AW-1:0], 32'hC0DE_0000 + i, 4'h0);
    idle("R7", 3);
    // R10: read, write, read same address
    rd("R10", 4'd2); wr("R10", 4'd2, 32'h2468_ACE0, 4'h0); rd("R10", 4'd2); idle("R10", 3);
    // R8: output enable high mid-cycle
    rd("R8", 4'd1); idle("R8", 1);
    @(posedge clk); #1;
    oeN = 1; #0.5;
    check("R8", doutEn === 1'b0, {31'd0, doutEn}, 32'd0);
    oeN = 0;
    @(negedge clk);
    h2V = 0; h1V = 0; h0V = 0;
    idle("R8", 3);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic a, c, g, oe; logic [3:0] b;
      a = ($urandom % 2) == 0; c = ($urandom % 5) == 0; g = ($urandom % 2) == 0;
      b = $urandom; oe = ($urandom % 10) == 0;
      doCycle("R6", a, c, g, b, $urandom, $urandom, oe);
    end
    idle("R6", 3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule